// File: doc/BRIEF.md
# 48-bit Seconds Counter with Coherent Two-Word Readout

This block keeps time as a 48-bit count of seconds, advanced by a slow tick-enable (nominally 32768 pulses per second) inside a single system clock. Software sees the count through two 32-bit words: a low word carrying seconds 31:0 and a high word carrying seconds 47:32 in its lower 16 bits. A latch mode in the control word makes a low-word read capture the high word, so a low-then-high read sequence always yields one coherent 48-bit value, even when a carry ripples into the high word between the two reads.

Time is set by writing the low word and then the high word. With transfer pacing enabled, each written word is held in a staging register and only applied after a fixed number of slow ticks. A per-word pending flag stays high meanwhile. With pacing disabled, a write is applied at once. A signed drift-trim value removes or adds slow ticks, spread evenly over a programmable period of one hour of ticks. The net correction per period equals the programmed value exactly.

Top module: `sec_counter48`

## Requirements
- R1: After reset the count is zero, both pending flags are 0, and the control word and the trim word read as zero.
- R2: The count rises by one for every TPS slow ticks, and it does not change in a cycle without a tick or a load. Counting past 0xFFFF_FFFF_FFFF wraps to zero.
- R3: Byte address 0x08 reads and writes seconds 31:0. Address 0x0C reads seconds 47:32 on bits 15:0 with bits 31:16 as zero. A write to 0x0C uses only wdata[15:0].
- R4: The control word at 0x50 holds the latch mode in bits 25:24. With value 2, a low-word read captures the high word, and the next high-word read returns that capture and releases it. With any other value, the high word reads live.
- R5: With control bit 21 set, a write to a count word sets its pending flag in the status word at 0x68 (bit 0 low word, bit 1 high word). The word is applied on the SYNC_TICKS-th tick after the write, and the flag clears on that tick. A new write to the same word restarts the wait.
- R6: With control bit 21 clear, a count-word write is applied at the clock edge of the write, and its pending flag stays 0.
- R7: Applying a low-word value clears the sub-second tick count. A word applied on a tick that would carry overrides the increment, and the other word keeps its value.
- R8: The trim word at 0x10 is a COMP_W-bit signed value in bits COMP_W-1:0, with the upper bits reading zero. A positive value c drops c ticks and a negative value inserts |c| extra ticks in every HOUR_TICKS ticks. Writing the trim word restarts that period.
- R9: A read of an unmapped address returns zero, and no read changes the count.
- R10: A low-word read in latch mode that coincides with a carrying tick captures the high word from before the carry, which matches the low word returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow-clock tick enable, one cycle per slow period |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en, zero otherwise |

## Verification
Two events can land in the same cycle. The first is a low-word read, arriving together with the tick that carries the low word into the high word. The bench provokes this by preloading the low word with all ones and drives the read strobe in the cycle of the carrying tick. It expects the following high-word read to return the pre-carry value, and a fresh pair of reads to return the carried value. The second is a staged low-word transfer that falls on a tick which would itself carry. The bench judges it by the loaded value appearing with the high word unchanged, and by the next increment arriving a full TPS ticks later.

// File: rtl/sc48_pkg.sv
package sc48_pkg;
    localparam int CNT_W    = 48;
    localparam int HI_W     = 16;
    localparam logic [7:0] A_SEC_LO = 8'h08;
    localparam logic [7:0] A_SEC_HI = 8'h0C;
    localparam logic [7:0] A_TRIM   = 8'h10;
    localparam logic [7:0] A_CTRL   = 8'h50;
    localparam logic [7:0] A_PEND   = 8'h68;
    localparam int PACE_BIT   = 21;
    localparam int LATCH_LSB  = 24;
    localparam logic [1:0] LATCH_ON = 2'd2;
endpackage

// File: rtl/sc48_tick_div.sv
module sc48_tick_div #(
    parameter int TPS        = 32768,
    parameter int HOUR_TICKS = 32768 * 3600,
    parameter int COMP_W     = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    input  logic              trim_wr,
    input  logic [COMP_W-1:0] trim,
    output logic              sec_inc
);
    localparam int PW = $clog2(TPS + 2);
    localparam int AW = $clog2(HOUR_TICKS + (2 ** COMP_W)) + 1;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [AW-1:0] acc;
    } div_t;

    div_t div_d, div_q;
    logic [COMP_W-1:0] mag;
    logic [AW-1:0]     acc_sum;
    logic [PW-1:0]     pre_sum;
    logic [1:0]        step;
    logic              adj;

    assign mag = trim[COMP_W-1] ? (~trim + COMP_W'(1)) : trim;

    always_comb begin
        div_d   = div_q;
        sec_inc = 1'b0;
        adj     = 1'b0;
        acc_sum = div_q.acc + AW'(mag);
        step    = 2'd1;
        pre_sum = div_q.pre;
        if (tick) begin
            if (acc_sum >= AW'(HOUR_TICKS)) begin
                adj       = 1'b1;
                div_d.acc = acc_sum - AW'(HOUR_TICKS);
            end else begin
                div_d.acc = acc_sum;
            end
            if (adj) begin
                step = trim[COMP_W-1] ? 2'd2 : 2'd0;
            end
            pre_sum = div_q.pre + PW'(step);
            if (pre_sum >= PW'(TPS)) begin
                div_d.pre = pre_sum - PW'(TPS);
                sec_inc   = 1'b1;
            end else begin
                div_d.pre = pre_sum;
            end
        end
        if (trim_wr) begin
            div_d.acc = '0;
        end
        if (clr) begin
            div_d.pre = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/sc48_xfer.sv
module sc48_xfer #(
    parameter int SYNC_TICKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        pace_en,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic        ld_lo,
    output logic        ld_hi,
    output logic [31:0] ld_lo_val,
    output logic [31:0] ld_hi_val,
    output logic [1:0]  pend
);
    localparam int CW = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        logic [31:0]   val;
        logic [CW-1:0] cnt;
    } stage_t;

    logic [1:0]  wr_vec;
    logic [1:0]  ld_vec;
    logic [31:0] val_vec [2];

    assign wr_vec = {wr_hi, wr_lo};

    for (genvar i = 0; i < 2; i++) begin : g_word
        stage_t st_d, st_q;
        logic   ld_i;

        always_comb begin
            st_d = st_q;
            ld_i = 1'b0;
            if (wr_vec[i]) begin
                if (pace_en) begin
                    st_d.val = wdata;
                    st_d.cnt = CW'(SYNC_TICKS);
                end else begin
                    ld_i     = 1'b1;
                    st_d.cnt = '0;
                end
            end else if (tick && (st_q.cnt != '0)) begin
                if (st_q.cnt == CW'(1)) begin
                    ld_i = 1'b1;
                end
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign ld_vec[i]  = ld_i;
        assign val_vec[i] = (wr_vec[i] && !pace_en) ? wdata : st_q.val;
        assign pend[i]    = (st_q.cnt != '0);
    end

    assign ld_lo     = ld_vec[0];
    assign ld_hi     = ld_vec[1];
    assign ld_lo_val = val_vec[0];
    assign ld_hi_val = val_vec[1];
endmodule

// File: rtl/sec_counter48.sv
module sec_counter48
    import sc48_pkg::*;
#(
    parameter int TPS        = 32768,
    parameter int HOUR_TICKS = 32768 * 3600,
    parameter int SYNC_TICKS = 2,
    parameter int COMP_W     = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HI_W-1:0]   hold;
        logic              frozen;
        logic              pace;
        logic [1:0]        latch;
        logic [COMP_W-1:0] trim;
    } core_t;

    core_t core_d, core_q;

    logic rd_lo, rd_hi, wr_lo, wr_hi, wr_trim, wr_ctrl;
    logic sec_inc, ld_lo, ld_hi;
    logic [31:0] ld_lo_val, ld_hi_val;
    logic [1:0]  pend;

    assign rd_lo   = rd_en && (addr == A_SEC_LO);
    assign rd_hi   = rd_en && (addr == A_SEC_HI);
    assign wr_lo   = wr_en && (addr == A_SEC_LO);
    assign wr_hi   = wr_en && (addr == A_SEC_HI);
    assign wr_trim = wr_en && (addr == A_TRIM);
    assign wr_ctrl = wr_en && (addr == A_CTRL);

    sc48_xfer #(.SYNC_TICKS(SYNC_TICKS)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pace_en   (core_q.pace),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wdata     (wdata),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .ld_lo_val (ld_lo_val),
        .ld_hi_val (ld_hi_val),
        .pend      (pend)
    );

    sc48_tick_div #(.TPS(TPS), .HOUR_TICKS(HOUR_TICKS), .COMP_W(COMP_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr     (ld_lo),
        .trim_wr (wr_trim),
        .trim    (core_q.trim),
        .sec_inc (sec_inc)
    );

    always_comb begin
        core_d = core_q;
        if (sec_inc) begin
            core_d.cnt = core_q.cnt + CNT_W'(1);
        end
        if (ld_lo) begin
            core_d.cnt = {core_q.cnt[CNT_W-1:32], ld_lo_val};
        end
        if (ld_hi) begin
            core_d.cnt[CNT_W-1:32] = ld_hi_val[HI_W-1:0];
        end
        if (rd_lo && (core_q.latch == LATCH_ON)) begin
            core_d.hold   = core_q.cnt[CNT_W-1:32];
            core_d.frozen = 1'b1;
        end else if (rd_hi) begin
            core_d.frozen = 1'b0;
        end
        if (wr_ctrl) begin
            core_d.pace  = wdata[PACE_BIT];
            core_d.latch = wdata[LATCH_LSB+1:LATCH_LSB];
        end
        if (wr_trim) begin
            core_d.trim = wdata[COMP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_SEC_LO: rdata = core_q.cnt[31:0];
                A_SEC_HI: rdata = {16'h0, core_q.frozen ? core_q.hold : core_q.cnt[CNT_W-1:32]};
                A_TRIM:   rdata = {{(32-COMP_W){1'b0}}, core_q.trim};
                A_CTRL: begin
                    rdata[PACE_BIT]                = core_q.pace;
                    rdata[LATCH_LSB+1:LATCH_LSB]   = core_q.latch;
                end
                A_PEND:   rdata = {30'h0, pend};
                default:  rdata = '0;
            endcase
        end
    end

    logic [CNT_W-1:0] count_now;
    logic             pace_now;
    logic [1:0]       latch_now;
    assign count_now = core_q.cnt;
    assign pace_now  = core_q.pace;
    assign latch_now = core_q.latch;
endmodule

// File: rtl/sc48_checker.sv
module sc48_checker
    import sc48_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             rd_en,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [31:0]      rdata,
    input logic [CNT_W-1:0] count_now,
    input logic             ld_lo,
    input logic             ld_hi,
    input logic             pace_now,
    input logic [1:0]       latch_now,
    input logic [1:0]       pend
);
    p_hi_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_SEC_HI) |-> (rdata[31:16] == 16'h0));

    p_step_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_lo && !ld_hi) |=> ((count_now == $past(count_now)) ||
                                (count_now == $past(count_now) + 48'd1)));

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_lo && !ld_hi) |=> $stable(count_now));

    p_latch_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_SEC_LO && latch_now == LATCH_ON) ##1 (rd_en && addr == A_SEC_HI)
        |-> (rdata[15:0] == $past(count_now[47:32])));

    p_no_pend_unpaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SEC_LO && !pace_now) |=> !pend[0]);

    p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SEC_HI && pace_now) |=> pend[1]);

    p_pend_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend[0]) |-> ($past(tick) || $past(wr_en)));
endmodule

bind sec_counter48 sc48_checker u_sc48_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .count_now (count_now),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .pace_now  (pace_now),
    .latch_now (latch_now),
    .pend      (pend)
);

// File: tb/sec_counter48_bench.sv
module sec_counter48_bench;
    localparam int TPS   = 4;
    localparam int HOUR  = 16;
    localparam logic [7:0] LO = 8'h08, HI = 8'h0C, TRIM = 8'h10, CTRL = 8'h50, PEND = 8'h68;
    localparam logic [31:0] C_LATCH = 32'h0200_0000;
    localparam logic [31:0] C_PACE  = 32'h0220_0000;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sec_counter48 #(.TPS(TPS), .HOUR_TICKS(HOUR), .SYNC_TICKS(2), .COMP_W(17)) u_sec_counter48 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic cyc(input logic tk, input logic rd, input logic wr, input logic [7:0] a,
                       input logic [31:0] wd, output logic [31:0] rv);
        @(negedge clk);
        tick = tk; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        #1 rv = rdata;
        @(posedge clk);
        #1 tick = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] unused;
        cyc(1'b0, 1'b0, 1'b1, a, d, unused);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cyc(1'b0, 1'b1, 1'b0, a, 32'h0, d);
    endtask

    task automatic ticks(input int n);
        logic [31:0] unused;
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h0, 32'h0, unused);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd48(output logic [47:0] v);
        logic [31:0] lo, hi;
        rd(LO, lo);
        rd(HI, hi);
        v = {hi[15:0], lo};
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(LO, v);   chk("R1 low", v, 0);
        rd(HI, v);   chk("R1 high", v, 0);
        rd(PEND, v); chk("R1 pend", v, 0);
        rd(CTRL, v); chk("R1 ctrl", v, 0);
        rd(TRIM, v); chk("R1 trim", v, 0);
        rd(8'h40, v); chk("R9 unmapped", v, 0);
    endtask

    task automatic t_count;
        logic [47:0] s;
        logic [31:0] v;
        wr(CTRL, C_LATCH);
        wr(LO, 0); wr(HI, 0);
        ticks(3); rd48(s); chk("R2 before first second", s, 0);
        ticks(1); rd48(s); chk("R2 one second", s, 1);
        ticks(8); rd48(s); chk("R2 three seconds", s, 3);
        repeat (5) @(negedge clk);
        rd48(s); chk("R2 R9 no tick no change", s, 3);
        wr(HI, 32'hABCD_1234); rd(HI, v); chk("R3 high keeps 16 bits", v, 32'h1234);
        wr(LO, 32'hDEAD_BEEF); rd(LO, v); chk("R3 low full word", v, 32'hDEAD_BEEF);
        wr(LO, 32'hFFFF_FFFF); wr(HI, 32'hFFFF);
        ticks(4); rd48(s); chk("R2 48-bit wrap", s, 0);
    endtask

    task automatic t_latch;
        logic [31:0] v;
        wr(CTRL, C_LATCH);
        wr(LO, 32'hFFFF_FFFF); wr(HI, 5);
        ticks(3);
        cyc(1'b1, 1'b1, 1'b0, LO, 32'h0, v); chk("R10 low on carry tick", v, 32'hFFFF_FFFF);
        rd(HI, v); chk("R10 R4 frozen high", v, 5);
        rd(LO, v); chk("R4 low after carry", v, 0);
        rd(HI, v); chk("R4 high after carry", v, 6);
        wr(CTRL, 0);
        wr(LO, 32'hFFFF_FFFF); wr(HI, 7);
        ticks(3);
        rd(LO, v);
        ticks(1);
        rd(HI, v); chk("R4 live high without latch", v, 8);
    endtask

    task automatic t_paced;
        logic [31:0] v;
        wr(CTRL, C_LATCH);
        wr(LO, 7); wr(HI, 0);
        ticks(2);
        wr(CTRL, C_PACE);
        wr(LO, 50);
        rd(PEND, v); chk("R5 low pending set", v, 1);
        ticks(1);
        rd(PEND, v); chk("R5 still pending", v, 1);
        rd(LO, v);   chk("R5 old value held", v, 7);
        ticks(1);
        rd(PEND, v); chk("R5 pending cleared", v, 0);
        rd(LO, v);   chk("R7 load overrides carry", v, 50);
        rd(HI, v);   chk("R7 high unchanged", v, 0);
        ticks(3); rd(LO, v); chk("R7 subsecond cleared", v, 50);
        ticks(1); rd(LO, v); chk("R7 next second", v, 51);
        wr(HI, 32'h0001_2345);
        rd(PEND, v); chk("R5 high pending bit1", v, 2);
        ticks(2);
        rd(PEND, v); chk("R5 high pending cleared", v, 0);
        rd(LO, v); rd(HI, v); chk("R5 R3 high applied", v, 32'h2345);
        wr(LO, 60); ticks(1); wr(LO, 70); ticks(1);
        rd(PEND, v); chk("R5 rewrite restarts wait", v, 1);
        ticks(1);
        rd(LO, v); chk("R5 rewritten value", v, 70);
    endtask

    task automatic t_unpaced;
        logic [31:0] v;
        wr(CTRL, C_LATCH);
        wr(LO, 123);
        rd(PEND, v); chk("R6 no pending", v, 0);
        rd(LO, v);   chk("R6 immediate load", v, 123);
    endtask

    task automatic t_trim(input logic [31:0] c, input logic [31:0] exp);
        logic [31:0] v;
        wr(CTRL, C_LATCH);
        wr(LO, 0); wr(HI, 0); wr(TRIM, c);
        ticks(64);
        rd(LO, v); chk("R8 trimmed seconds", v, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_count();
        t_latch();
        t_paced();
        t_unpaced();
        t_trim(32'd0, 16);
        t_trim(32'd4, 12);
        t_trim(32'hFFFF_FFFC, 20);
        begin
            logic [31:0] v;
            rd(TRIM, v); chk("R8 trim width", v, 32'h0001_FFFC);
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule